// File: doc/BRIEF.md
# Line Test Pattern Generator and Checker

This block produces a maintenance test stream on one channel's NRZ transmit data and checks the same kind of stream on the receive side. The stream can be a steady mark level (all ones), a steady space level (all zeros), or a pseudo-random sequence. The line standard picks the sequence. The short-haul E1 standard uses a 15-stage maximal-length sequence. The T1/J1 standard uses a 20-stage sequence, and its transmitted form never holds more than fourteen zeros in a row.

Both halves step on one reference tick. A select input takes that tick from either the transmit-clock strobe or the master-clock strobe, and the strobe that is not selected has no effect. A one-cycle request inverts exactly one transmitted bit, which lets the far end or the local checker prove that it sees errors. The checker seeds itself from the bits it receives. It declares sync after a run of correct predictions and then runs its own reference freely. For each wrong bit it pulses a strobe that an outside 16-bit counter can count. When too many errors fall inside one observation window, it goes back to searching. Every change of sync state also gives a one-cycle pulse that can raise an interrupt.

Top module: `ptg_top`

## Requirements
- R1: During and straight after reset, tx_bit, sync, bit_err and sync_chg are 0, the generator register holds all ones, the checker history holds all zeros, and the checker is searching.
- R2: pat_sel 00 transmits all ones, 01 all zeros, and 1x the pseudo-random sequence. tx_bit changes only on a clock edge where the selected tick is high, and it shows the new bit from the clock after that edge.
- R3: With ref_sel 0 both halves step on tx_tick, and with ref_sel 1 they step on mst_tick. The strobe that is not selected has no effect on either half.
- R4: With std_sel 0, each random bit is the XOR of the bits sent 15 and 14 ticks earlier (x^15+x^14+1). The bit sent is the new feedback bit. An all-zero 15-bit state is reloaded with ones before the step.
- R5: With std_sel 1, the raw register steps as x^20+x^17+1. The bit sent is the raw bit 14 places behind the newest, forced to 1 when the 14 newer raw bits are all zero, so no run of zeros in the stream is longer than 14.
- R6: An err_ins pulse in any cycle inverts the next transmitted bit, or the bit of the same cycle if the tick is high. Any number of pulses before that tick cause one inversion only.
- R7: The checker samples rx_bit on the selected tick. While searching it shifts received bits into its history and declares sync after 32 consecutive correct predictions. sync_chg pulses for one clock on every change of sync.
- R8: While in sync, bit_err is high for one clock after each tick whose received bit differs from the expected bit. bit_err stays low while searching and on clocks without a tick.
- R9: The error window is 64 ticks long and starts when sync is declared. Reaching 6 errors inside one window returns the checker to searching. The error count clears at each window end.
- R10: In random mode, an all-zero checker history counts as a mismatch, so a stream of all zeros never gives sync.
- R11: While in sync on the random pattern, the checker history is fed from its own prediction and not from the line, so one flipped received bit gives exactly one bit_err pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_tick | input | 1 | Bit strobe from the transmit clock |
| mst_tick | input | 1 | Bit strobe from the master clock |
| ref_sel | input | 1 | 0 selects tx_tick, 1 selects mst_tick |
| pat_sel | input | 2 | 00 ones, 01 zeros, 1x random |
| std_sel | input | 1 | 0 E1 sequence, 1 T1/J1 quasi-random sequence |
| err_ins | input | 1 | Single-bit error insertion request |
| rx_bit | input | 1 | Received NRZ data |
| tx_bit | output | 1 | Generated NRZ data |
| sync | output | 1 | Checker is in sync |
| bit_err | output | 1 | One-clock strobe per erroneous received bit |
| sync_chg | output | 1 | One-clock pulse on each change of sync |

## Verification
The transmit stream is looped back to the receiver and compared against a bench model under every pattern code and both standards. The E1 stream is also checked against its two-tap recurrence. The T1/J1 stream is watched for runs of more than 14 zeros, which shows whether the forcing rule is in place. The bench flips received bits in three ways: one bit, five in a row and eleven in a row. These show a single error strobe, the window staying locked below the threshold, and a loss of sync followed by a new lock. An all-zero receive stream confirms that the checker cannot lock on a dead line. Two error requests made under the master tick while only the transmit strobe toggles show one thing: the strobe that is not selected does nothing, and the two requests fold into one inversion.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
    localparam int LONG_W    = 20;
    localparam int LONG_TAP  = 17;
    localparam int SHORT_W   = 15;
    localparam int SHORT_TAP = 14;
    localparam int SUPP_RUN  = 14;
    localparam int SYNC_RUN  = 32;
    localparam int WIN_LEN   = 64;
    localparam int LOSS_ERRS = 6;

    typedef enum logic {
        CHK_SEARCH = 1'b0,
        CHK_LOCK   = 1'b1
    } chk_st_e;
endpackage

// File: rtl/ptg_tick_sel.sv
module ptg_tick_sel (
    input  logic tx_tick,
    input  logic mst_tick,
    input  logic ref_sel,
    output logic tick
);
    always_comb begin
        tick = ref_sel ? mst_tick : tx_tick;
    end
endmodule

// File: rtl/ptg_gen.sv
module ptg_gen #(
    parameter int LONG_W    = ptg_pkg::LONG_W,
    parameter int LONG_TAP  = ptg_pkg::LONG_TAP,
    parameter int SHORT_W   = ptg_pkg::SHORT_W,
    parameter int SHORT_TAP = ptg_pkg::SHORT_TAP,
    parameter int SUPP_RUN  = ptg_pkg::SUPP_RUN
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] pat_sel,
    input  logic       std_sel,
    input  logic       err_ins,
    output logic       tx_o
);
    typedef struct packed {
        logic [LONG_W-1:0] lfsr;
        logic              pend;
        logic              tx;
    } gen_s;

    gen_s gen_d, gen_q;

    logic [LONG_W-1:0] p_eff;
    logic [LONG_W-1:0] p_next;
    logic              fb;
    logic              rand_bit;
    logic              pat_bit;
    logic              inv;

    always_comb begin
        gen_d = gen_q;
        p_eff = gen_q.lfsr;
        if (std_sel ? (~|gen_q.lfsr) : (~|gen_q.lfsr[SHORT_W-1:0])) begin
            p_eff = '1;
        end
        fb = std_sel ? (p_eff[LONG_W-1] ^ p_eff[LONG_TAP-1])
                     : (p_eff[SHORT_W-1] ^ p_eff[SHORT_TAP-1]);
        p_next   = {p_eff[LONG_W-2:0], fb};
        rand_bit = std_sel ? (p_next[SUPP_RUN] | ~|p_next[SUPP_RUN-1:0]) : fb;
        pat_bit  = pat_sel[1] ? rand_bit : ~pat_sel[0];
        inv      = gen_q.pend | err_ins;
        if (tick) begin
            gen_d.lfsr = p_next;
            gen_d.tx   = pat_bit ^ inv;
            gen_d.pend = 1'b0;
        end else begin
            gen_d.pend = inv;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_q      <= '0;
            gen_q.lfsr <= '1;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign tx_o = gen_q.tx;

    // R2
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(tx_o));

    // R6
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !gen_q.pend);
endmodule

// File: rtl/ptg_chk.sv
module ptg_chk #(
    parameter int LONG_W    = ptg_pkg::LONG_W,
    parameter int LONG_TAP  = ptg_pkg::LONG_TAP,
    parameter int SHORT_W   = ptg_pkg::SHORT_W,
    parameter int SHORT_TAP = ptg_pkg::SHORT_TAP,
    parameter int SUPP_RUN  = ptg_pkg::SUPP_RUN,
    parameter int SYNC_RUN  = ptg_pkg::SYNC_RUN,
    parameter int WIN_LEN   = ptg_pkg::WIN_LEN,
    parameter int LOSS_ERRS = ptg_pkg::LOSS_ERRS
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] pat_sel,
    input  logic       std_sel,
    input  logic       rx_i,
    output logic       lock_o,
    output logic       err_o,
    output logic       chg_o
);
    import ptg_pkg::*;

    localparam int RUN_W = $clog2(SYNC_RUN);
    localparam int WIN_W = $clog2(WIN_LEN);
    localparam int ERR_W = $clog2(LOSS_ERRS + 1);

    typedef struct packed {
        logic [LONG_W-1:0] hist;
        chk_st_e           st;
        logic [RUN_W-1:0]  run;
        logic [WIN_W-1:0]  win;
        logic [ERR_W-1:0]  errs;
        logic              err;
        logic              chg;
    } chk_s;

    chk_s chk_d, chk_q;

    logic [LONG_W-1:0] h;
    logic              e0_long;
    logic              e0_short;
    logic              fut_any;
    logic              hist_zero;
    logic              raw_next;
    logic              exp_bit;
    logic              mism;
    logic [ERR_W-1:0]  errs_nx;

    always_comb begin
        h        = chk_q.hist;
        e0_long  = h[LONG_W-1] ^ h[LONG_TAP-1];
        e0_short = h[SHORT_W-1] ^ h[SHORT_TAP-1];
        fut_any  = 1'b0;
        for (int i = 1; i <= SUPP_RUN; i++) begin
            fut_any = fut_any | (h[LONG_W-1-i] ^ h[LONG_TAP-1-i]);
        end
        hist_zero = std_sel ? (~|h) : (~|h[SHORT_W-1:0]);
        raw_next  = std_sel ? e0_long : e0_short;
        if (pat_sel[1]) begin
            exp_bit = std_sel ? (e0_long | ~fut_any) : e0_short;
        end else begin
            exp_bit = ~pat_sel[0];
        end
        mism    = (rx_i != exp_bit) | (pat_sel[1] & hist_zero);
        errs_nx = chk_q.errs + ERR_W'(mism);

        chk_d     = chk_q;
        chk_d.err = 1'b0;
        chk_d.chg = 1'b0;
        if (tick) begin
            if (chk_q.st == CHK_SEARCH) begin
                chk_d.hist = {h[LONG_W-2:0], rx_i};
                if (mism) begin
                    chk_d.run = '0;
                end else if (chk_q.run == RUN_W'(SYNC_RUN - 1)) begin
                    chk_d.st   = CHK_LOCK;
                    chk_d.chg  = 1'b1;
                    chk_d.run  = '0;
                    chk_d.win  = '0;
                    chk_d.errs = '0;
                end else begin
                    chk_d.run = chk_q.run + 1'b1;
                end
            end else begin
                chk_d.hist = {h[LONG_W-2:0], pat_sel[1] ? raw_next : rx_i};
                chk_d.err  = mism;
                if (errs_nx >= ERR_W'(LOSS_ERRS)) begin
                    chk_d.st   = CHK_SEARCH;
                    chk_d.chg  = 1'b1;
                    chk_d.run  = '0;
                    chk_d.win  = '0;
                    chk_d.errs = '0;
                end else if (chk_q.win == WIN_W'(WIN_LEN - 1)) begin
                    chk_d.win  = '0;
                    chk_d.errs = '0;
                end else begin
                    chk_d.win  = chk_q.win + 1'b1;
                    chk_d.errs = errs_nx;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_q <= '0;
        end else begin
            chk_q <= chk_d;
        end
    end

    assign lock_o = (chk_q.st == CHK_LOCK);
    assign err_o  = chk_q.err;
    assign chg_o  = chk_q.chg;

    // R7
    sync_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lock_o) |-> chg_o);

    // R8
    err_in_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (lock_o || chg_o));

    // R9
    errs_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |-> (chk_q.errs < ERR_W'(LOSS_ERRS)));

    // R7
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_o |-> (int'(chk_q.run) < SYNC_RUN));
endmodule

// File: rtl/ptg_top.sv
module ptg_top #(
    parameter int LONG_W    = ptg_pkg::LONG_W,
    parameter int LONG_TAP  = ptg_pkg::LONG_TAP,
    parameter int SHORT_W   = ptg_pkg::SHORT_W,
    parameter int SHORT_TAP = ptg_pkg::SHORT_TAP,
    parameter int SUPP_RUN  = ptg_pkg::SUPP_RUN,
    parameter int SYNC_RUN  = ptg_pkg::SYNC_RUN,
    parameter int WIN_LEN   = ptg_pkg::WIN_LEN,
    parameter int LOSS_ERRS = ptg_pkg::LOSS_ERRS
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_tick,
    input  logic       mst_tick,
    input  logic       ref_sel,
    input  logic [1:0] pat_sel,
    input  logic       std_sel,
    input  logic       err_ins,
    input  logic       rx_bit,
    output logic       tx_bit,
    output logic       sync,
    output logic       bit_err,
    output logic       sync_chg
);
    logic tick;

    ptg_tick_sel u_tick (
        .tx_tick  (tx_tick),
        .mst_tick (mst_tick),
        .ref_sel  (ref_sel),
        .tick     (tick)
    );

    ptg_gen #(
        .LONG_W    (LONG_W),
        .LONG_TAP  (LONG_TAP),
        .SHORT_W   (SHORT_W),
        .SHORT_TAP (SHORT_TAP),
        .SUPP_RUN  (SUPP_RUN)
    ) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .pat_sel (pat_sel),
        .std_sel (std_sel),
        .err_ins (err_ins),
        .tx_o    (tx_bit)
    );

    ptg_chk #(
        .LONG_W    (LONG_W),
        .LONG_TAP  (LONG_TAP),
        .SHORT_W   (SHORT_W),
        .SHORT_TAP (SHORT_TAP),
        .SUPP_RUN  (SUPP_RUN),
        .SYNC_RUN  (SYNC_RUN),
        .WIN_LEN   (WIN_LEN),
        .LOSS_ERRS (LOSS_ERRS)
    ) u_chk (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .pat_sel (pat_sel),
        .std_sel (std_sel),
        .rx_i    (rx_bit),
        .lock_o  (sync),
        .err_o   (bit_err),
        .chg_o   (sync_chg)
    );

    // R8
    err_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_err |-> $past(tick));
endmodule

// File: tb/sim_ptg_top.sv
module sim_ptg_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_tick = 1'b0;
    logic       mst_tick = 1'b0;
    logic       ref_sel = 1'b0;
    logic [1:0] pat_sel = 2'b10;
    logic       std_sel = 1'b0;
    logic       err_ins = 1'b0;
    logic       rx_flip = 1'b0;
    logic       rx_zero = 1'b0;
    logic       rx_bit;
    logic       tx_bit, sync, bit_err, sync_chg;

    always #10 clk = ~clk;

    assign rx_bit = rx_zero ? 1'b0 : (tx_bit ^ rx_flip);

    ptg_top u0 (
        .clk(clk), .rst_n(rst_n), .tx_tick(tx_tick), .mst_tick(mst_tick),
        .ref_sel(ref_sel), .pat_sel(pat_sel), .std_sel(std_sel),
        .err_ins(err_ins), .rx_bit(rx_bit), .tx_bit(tx_bit), .sync(sync),
        .bit_err(bit_err), .sync_chg(sync_chg)
    );

    int n_chk = 0;
    int n_fail = 0;

    // behavioural reference state
    bit gq[$];
    bit cq[$];
    bit m_tx = 0, m_pend = 0, m_lock = 0, m_err = 0, m_chg = 0;
    int m_run = 0, m_win = 0, m_errs = 0;

    // observation
    bit txh[$];
    int zrun = 0, maxz = 0, nerr = 0, nrise = 0, cyc_no = 0;
    int tx_div = 1, mst_div = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit all_zero(ref bit q[$], input int n);
        for (int k = 0; k < n; k++) if (q[q.size()-1-k]) return 0;
        return 1;
    endfunction

    task automatic model_step(input bit tk);
        bit rx, expb, raw, zh, mism, fb, bitv, inv;
        bit tmp[$];
        rx = rx_zero ? 1'b0 : (m_tx ^ rx_flip);
        // checker reference
        m_err = 0; m_chg = 0;
        if (tk) begin
            zh = 0; raw = 0;
            if (!pat_sel[1]) expb = !pat_sel[0];
            else if (!std_sel) begin
                raw = cq[cq.size()-15] ^ cq[cq.size()-14];
                expb = raw; zh = all_zero(cq, 15);
            end else begin
                tmp = cq;
                for (int k = 0; k < 15; k++)
                    tmp.push_back(tmp[tmp.size()-20] ^ tmp[tmp.size()-17]);
                raw = tmp[tmp.size()-15];
                expb = raw | all_zero(tmp, 14);
                zh = all_zero(cq, 20);
            end
            mism = (rx != expb) || (pat_sel[1] && zh);
            if (!m_lock) begin
                cq.push_back(rx);
                if (mism) m_run = 0;
                else if (m_run == 31) begin
                    m_lock = 1; m_chg = 1; m_run = 0; m_win = 0; m_errs = 0;
                end else m_run++;
            end else begin
                cq.push_back(pat_sel[1] ? raw : rx);
                m_err = mism;
                if (m_errs + mism >= 6) begin
                    m_lock = 0; m_chg = 1; m_run = 0; m_win = 0; m_errs = 0;
                end else if (m_win == 63) begin
                    m_win = 0; m_errs = 0;
                end else begin
                    m_win++; m_errs += mism;
                end
            end
            if (cq.size() > 40) void'(cq.pop_front());
        end
        // generator reference
        inv = m_pend | err_ins;
        if (tk) begin
            if (all_zero(gq, std_sel ? 20 : 15))
                for (int k = 0; k < 20; k++) gq[gq.size()-1-k] = 1;
            if (!std_sel) fb = gq[gq.size()-15] ^ gq[gq.size()-14];
            else fb = gq[gq.size()-20] ^ gq[gq.size()-17];
            gq.push_back(fb);
            if (!std_sel) bitv = fb;
            else bitv = gq[gq.size()-15] | all_zero(gq, 14);
            if (!pat_sel[1]) bitv = !pat_sel[0];
            m_tx = bitv ^ inv;
            m_pend = 0;
            if (gq.size() > 40) void'(gq.pop_front());
        end else m_pend = inv;
    endtask

    task automatic compare();
        string rq;
        rq = pat_sel[1] ? (std_sel ? "R5" : "R4") : "R2";
        check(tx_bit == m_tx, rq, tx_bit, m_tx);
        check(sync == m_lock, "R7 sync", sync, m_lock);
        check(sync_chg == m_chg, "R7 sync_chg", sync_chg, m_chg);
        check(bit_err == m_err, "R8 bit_err", bit_err, m_err);
    endtask

    task automatic cyc();
        bit tk;
        cyc_no++;
        tx_tick  = (tx_div > 0) ? ((cyc_no % tx_div) == 0) : 1'b0;
        mst_tick = (mst_div > 0) ? ((cyc_no % mst_div) == 0) : 1'b0;
        tk = ref_sel ? mst_tick : tx_tick;
        model_step(tk);
        @(negedge clk);
        compare();
        if (tk) begin
            txh.push_back(tx_bit);
            if (txh.size() > 400) void'(txh.pop_front());
            if (tx_bit == 1'b0) zrun++; else zrun = 0;
            if (std_sel && pat_sel[1] && zrun > maxz) maxz = zrun;
        end
        if (bit_err) nerr++;
        if (sync_chg && sync) nrise++;
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int bad;
        for (int k = 0; k < 20; k++) begin gq.push_back(1); cq.push_back(0); end
        repeat (4) @(negedge clk);
        // R1: reset state
        check(tx_bit == 0 && sync == 0 && bit_err == 0 && sync_chg == 0, "R1", {tx_bit, sync, bit_err, sync_chg}, 0);
        rst_n = 1'b1;

        // E1 random, transmit strobe every clock
        run(60);
        check(sync == 1, "R7 lock on E1 sequence", sync, 1);
        txh.delete();
        run(200);
        bad = 0;
        for (int n = 15; n < txh.size(); n++)
            if (txh[n] != (txh[n-15] ^ txh[n-14])) bad++;
        check(bad == 0, "R4 recurrence", bad, 0);

        // R11: single received flip, exactly one strobe
        run(70);
        nerr = 0;
        rx_flip = 1; cyc(); rx_flip = 0;
        run(5);
        check(nerr == 1, "R11 single flip", nerr, 1);
        check(sync == 1, "R11 stays locked", sync, 1);

        // R9: five errors stay below threshold, eleven lose sync
        run(70);
        rx_flip = 1; run(5); rx_flip = 0;
        run(3);
        check(sync == 1, "R9 below threshold", sync, 1);
        run(70);
        rx_flip = 1; run(11); rx_flip = 0;
        run(3);
        check(sync == 0, "R9 loss of sync", sync, 0);
        run(80);
        check(sync == 1, "R7 relock", sync, 1);

        // R5: quasi-random sequence
        std_sel = 1; maxz = 0; zrun = 0;
        run(1500);
        check(maxz <= 14, "R5 zero run limit", maxz, 14);
        check(sync == 1, "R5 lock on T1 sequence", sync, 1);

        // R2: fixed patterns
        pat_sel = 2'b00; run(100);
        check(tx_bit == 1 && sync == 1, "R2 all ones", tx_bit, 1);
        pat_sel = 2'b01; run(100);
        check(tx_bit == 0 && sync == 1, "R2 all zeros", tx_bit, 0);

        // R3 and R6: master strobe selected, transmit strobe toggling only
        pat_sel = 2'b00; run(60);
        ref_sel = 1; tx_div = 1; mst_div = 0;
        err_ins = 1; cyc(); cyc(); err_ins = 0;
        run(5);
        check(tx_bit == 1, "R3 unselected strobe ignored", tx_bit, 1);
        mst_div = 1; cyc(); mst_div = 0;
        check(tx_bit == 0, "R6 one inversion applied", tx_bit, 0);
        mst_div = 1; cyc(); mst_div = 0;
        check(tx_bit == 1, "R6 inversion not repeated", tx_bit, 1);
        tx_div = 2; mst_div = 3; pat_sel = 2'b10; std_sel = 0;
        run(400);
        check(sync == 1, "R3 lock on master strobe", sync, 1);

        // R10: dead line never locks
        ref_sel = 0; tx_div = 1; mst_div = 0;
        rx_zero = 1; run(100);
        nrise = 0; run(200);
        check(sync == 0 && nrise == 0, "R10 no lock on zeros", nrise, 0);

        finish_run();
    end
endmodule